// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits between two independent memory ports and the shared storage array they address. On every clock it compares the two ports' addresses. When both ports are enabled and point at the same word, it decides which port keeps access. It then pulls an active-low busy flag low toward the losing port and withholds that port's write strobe from the storage. Reads are never blocked. A losing port's read data is simply not guaranteed while its busy flag is low.

The winner is chosen from what happened first. A port is called "settled" when it was already enabled in the previous cycle and its address has not changed since then.
- When a collision appears, a settled port wins over a port that is not settled.
- This single rule covers two cases. The port whose enable rose later loses, and so does the port whose address moved onto the other port's address.
- When neither port or both ports are settled, the left port wins by fixed priority.
- The winner keeps ownership for as long as the collision lasts. Busy is released when the addresses part or when either enable drops.

A mode input selects master or slave operation, so that several devices can be cascaded. In master mode the block drives its own busy flags. In slave mode its busy outputs stay high, and two external busy inputs, which come from a master device, decide which writes are blocked.

Top module: `dpa_busy_arbiter`

## Requirements
- R1: While reset (rst_n low at a clock edge) is applied, both busy outputs read 1 and both write strobes read 0 after that edge, whatever the port inputs are.
- R2: With both ports enabled, if one port's address changes onto the other's unchanged address, the moving port's busy goes to 0 one cycle later and the other port's busy stays 1.
- R3: Once the two enabled addresses differ again, the losing port's busy returns to 1 one cycle later.
- R4: If the addresses are already equal when the enables arrive, the port whose enable became 1 in a later cycle sees busy 0 one cycle after its enable rises.
- R5: When the winning port's enable goes to 0, the loser's busy returns to 1 one cycle later.
- R6: If both ports reach a match in the same cycle (both enables rising together, or both addresses moving together), the left port wins and busy_r_n goes to 0.
- R7: A write strobe output is 1 one cycle after its port presents enable, write and write-data-valid all at 1 without being blocked. A port that loses arbitration gets a strobe of 0 in the same cycle that its busy goes to 0.
- R8: With mode_master at 0, both busy outputs stay at 1, and a port's write is blocked exactly when its external busy input is 0. With mode_master at 1, the external busy inputs have no effect.
- R9: The two busy outputs are never both at 0.
- R10: If either port is disabled, neither busy output goes to 0, even when the addresses are equal.
- R11: A write with write-data-valid at 0 produces no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_master | input | 1 | 1: busy is generated locally; 0: busy is taken from the external inputs |
| ce_l | input | 1 | Left port enable, active high |
| addr_l | input | ADDR_W | Left port address |
| wr_l | input | 1 | Left port write request |
| wvalid_l | input | 1 | Left port write data valid |
| ce_r | input | 1 | Right port enable, active high |
| addr_r | input | ADDR_W | Right port address |
| wr_r | input | 1 | Right port write request |
| wvalid_r | input | 1 | Right port write data valid |
| ext_busy_l_n | input | 1 | External busy for the left port, active low (slave mode) |
| ext_busy_r_n | input | 1 | External busy for the right port, active low (slave mode) |
| busy_l_n | output | 1 | Busy toward the left port, active low |
| busy_r_n | output | 1 | Busy toward the right port, active low |
| we_l | output | 1 | Write strobe to storage for the left port |
| we_r | output | 1 | Write strobe to storage for the right port |

## Verification
The bench builds the block with ADDR_W set to 4. This keeps the address values short and readable, while still letting addresses differ, coincide and move from one cycle to the next. With that width the bench can directly produce each way a collision begins:
- an address moving onto the other port's address,
- an enable rising onto an already-matching address,
- both ports arriving in the same cycle.

It then also produces each way a collision ends. The slave-mode cases use the external busy inputs to block each port's write in turn.

// File: rtl/dpa_pkg.sv
// Package: shared types for the dual-port collision arbiter.
// Assumes two ports, indexed 0 = left and 1 = right.
package dpa_pkg;
    localparam int unsigned NPORTS   = 2;
    localparam int unsigned PORT_L   = 0;
    localparam int unsigned PORT_R   = 1;

    // Which port currently owns a colliding address.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/dpa_port_track.sv
// Module: dpa_port_track
// Keeps one cycle of history for a single port and reports whether the port
// is "settled": enabled now and last cycle, with an unchanged address.
// Assumes the enable and address are already synchronous to clk.
module dpa_port_track #(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic [ADDR_W-1:0] addr,
    output logic              settled
);
    logic              ce_q;
    logic [ADDR_W-1:0] addr_q;

    // Capture the previous cycle's enable and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            ce_q   <= ce;
            addr_q <= addr;
        end
    end

    // A port is settled when nothing about its access moved since last cycle.
    always_comb begin
        settled = ce && ce_q && (addr == addr_q);
    end

    // A settled port must have been enabled in the previous cycle.
    assert_settled_history_R4: assert property (@(posedge clk) disable iff (!rst_n)
        settled |-> $past(ce));
endmodule

// File: rtl/dpa_collision_arb.sv
// Module: dpa_collision_arb
// Detects an address collision between two enabled ports and decides the
// owner. A settled port beats an unsettled one; a tie goes to the left port.
// Ownership holds while the collision persists. The outputs lose_l/lose_r are
// next-cycle decisions that the caller registers.
// Assumes both inputs are sampled on the same clock.
module dpa_collision_arb
    import dpa_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_l,
    input  logic              ce_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic              settled_l,
    input  logic              settled_r,
    output logic              match,
    output logic              lose_l,
    output logic              lose_r
);
    owner_e owner_q;
    owner_e owner_d;

    // Collision condition: both enabled and pointing at one word.
    always_comb begin
        match = ce_l && ce_r && (addr_l == addr_r);
    end

    // Next owner: keep the incumbent, else pick by settledness, else the left port.
    always_comb begin
        owner_d = OWN_NONE;
        if (match) begin
            if (owner_q != OWN_NONE) begin
                owner_d = owner_q;
            end else if (settled_r && !settled_l) begin
                owner_d = OWN_RIGHT;
            end else begin
                owner_d = OWN_LEFT;
            end
        end
    end

    // Owner register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= OWN_NONE;
        end else begin
            owner_q <= owner_d;
        end
    end

    // The loser is the port that does not own the collision.
    always_comb begin
        lose_l = (owner_d == OWN_RIGHT);
        lose_r = (owner_d == OWN_LEFT);
    end

    // The owner does not change while the collision lasts.
    assert_owner_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q != OWN_NONE && match) |=> (owner_q == $past(owner_q)));

    // When both ports arrive together, the left port wins.
    assert_tie_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == OWN_NONE && match && !settled_l && !settled_r) |=> (owner_q == OWN_LEFT));

    // There is never an owner without a collision.
    assert_owner_needs_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> (owner_q == OWN_NONE));
endmodule

// File: rtl/dpa_write_gate.sv
// Module: dpa_write_gate
// Produces the registered write strobe for one port. The write is blocked
// either by the local arbitration loss (master mode) or by the external
// active-low busy (slave mode).
// Assumes lose_local is the same-cycle decision that sets the port's busy.
module dpa_write_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic wr,
    input  logic wvalid,
    input  logic mode_master,
    input  logic lose_local,
    input  logic ext_busy_n,
    output logic we
);
    logic block;

    // Select the blocking source according to the mode.
    always_comb begin
        block = mode_master ? lose_local : !ext_busy_n;
    end

    // Register the qualified strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we <= 1'b0;
        end else begin
            we <= ce && wr && wvalid && !block;
        end
    end

    // A port that has lost arbitration in master mode never writes.
    assert_loser_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && lose_local) |=> !we);

    // Without valid write data there is no strobe.
    assert_need_wvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wvalid |=> !we);

    // In slave mode a low external busy blocks the write.
    assert_slave_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && !ext_busy_n) |=> !we);
endmodule

// File: rtl/dpa_busy_arbiter.sv
// Module: dpa_busy_arbiter (top)
// Collision arbiter for two memory ports sharing one storage array. It drives
// active-low busy flags in master mode and gates each port's write strobe.
// Assumes all inputs are synchronous to clk. Busy and write strobes appear
// one cycle after the inputs that cause them.
module dpa_busy_arbiter
    import dpa_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_master,
    input  logic              ce_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic              wr_l,
    input  logic              wvalid_l,
    input  logic              ce_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic              wr_r,
    input  logic              wvalid_r,
    input  logic              ext_busy_l_n,
    input  logic              ext_busy_r_n,
    output logic              busy_l_n,
    output logic              busy_r_n,
    output logic              we_l,
    output logic              we_r
);
    logic [NPORTS-1:0] ce_a;
    logic [NPORTS-1:0] wr_a;
    logic [NPORTS-1:0] wvalid_a;
    logic [NPORTS-1:0] ext_busy_n_a;
    logic [NPORTS-1:0] settled_a;
    logic [NPORTS-1:0] lose_a;
    logic [NPORTS-1:0] we_a;
    logic [NPORTS-1:0] busy_n_q;
    logic [ADDR_W-1:0] addr_a [NPORTS];
    logic              match;

    // Gather the per-port inputs into vectors indexed by port.
    always_comb begin
        ce_a[PORT_L]         = ce_l;
        ce_a[PORT_R]         = ce_r;
        wr_a[PORT_L]         = wr_l;
        wr_a[PORT_R]         = wr_r;
        wvalid_a[PORT_L]     = wvalid_l;
        wvalid_a[PORT_R]     = wvalid_r;
        ext_busy_n_a[PORT_L] = ext_busy_l_n;
        ext_busy_n_a[PORT_R] = ext_busy_r_n;
        addr_a[PORT_L]       = addr_l;
        addr_a[PORT_R]       = addr_r;
    end

    dpa_collision_arb #(.ADDR_W(ADDR_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_l      (ce_l),
        .ce_r      (ce_r),
        .addr_l    (addr_l),
        .addr_r    (addr_r),
        .settled_l (settled_a[PORT_L]),
        .settled_r (settled_a[PORT_R]),
        .match     (match),
        .lose_l    (lose_a[PORT_L]),
        .lose_r    (lose_a[PORT_R])
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        dpa_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .ce      (ce_a[p]),
            .addr    (addr_a[p]),
            .settled (settled_a[p])
        );

        dpa_write_gate u_gate (
            .clk         (clk),
            .rst_n       (rst_n),
            .ce          (ce_a[p]),
            .wr          (wr_a[p]),
            .wvalid      (wvalid_a[p]),
            .mode_master (mode_master),
            .lose_local  (lose_a[p]),
            .ext_busy_n  (ext_busy_n_a[p]),
            .we          (we_a[p])
        );

        // Busy register: low only for a loser in master mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_n_q[p] <= 1'b1;
            end else begin
                busy_n_q[p] <= !(mode_master && lose_a[p]);
            end
        end
    end

    // Drive the outputs.
    always_comb begin
        busy_l_n = busy_n_q[PORT_L];
        busy_r_n = busy_n_q[PORT_R];
        we_l     = we_a[PORT_L];
        we_r     = we_a[PORT_R];
    end

    // The two busy flags are never low together.
    assert_busy_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_l_n || busy_r_n);

    // A low busy is always preceded by an address match between enabled ports.
    assert_busy_needs_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_l_n |-> $past(ce_l && ce_r && (addr_l == addr_r)));

    // A port that is disabled never causes busy.
    assert_disabled_no_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce_l && ce_r) |=> (busy_l_n && busy_r_n));

    // In slave mode the local busy flags stay high.
    assert_slave_busy_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_master |=> (busy_l_n && busy_r_n));

    // A different address in the previous cycle means no busy now.
    assert_busy_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_l != addr_r) |=> (busy_l_n && busy_r_n));
endmodule

// File: tb/dpa_busy_arbiter_tb.sv
// Directed bench for dpa_busy_arbiter: one task per scenario.
module dpa_busy_arbiter_tb;
    localparam int unsigned AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_master = 1'b1;
    logic          ce_l = 1'b0, ce_r = 1'b0;
    logic [AW-1:0] addr_l = '0, addr_r = '0;
    logic          wr_l = 1'b0, wr_r = 1'b0;
    logic          wvalid_l = 1'b0, wvalid_r = 1'b0;
    logic          ext_busy_l_n = 1'b1, ext_busy_r_n = 1'b1;
    logic          busy_l_n, busy_r_n, we_l, we_r;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dpa_busy_arbiter #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_master(mode_master),
        .ce_l(ce_l), .addr_l(addr_l), .wr_l(wr_l), .wvalid_l(wvalid_l),
        .ce_r(ce_r), .addr_r(addr_r), .wr_r(wr_r), .wvalid_r(wvalid_r),
        .ext_busy_l_n(ext_busy_l_n), .ext_busy_r_n(ext_busy_r_n),
        .busy_l_n(busy_l_n), .busy_r_n(busy_r_n), .we_l(we_l), .we_r(we_r)
    );

    // Advance one edge and settle one time unit after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic idle();
        ce_l = 0; ce_r = 0; wr_l = 0; wr_r = 0; wvalid_l = 0; wvalid_r = 0;
        addr_l = 0; addr_r = 0; ext_busy_l_n = 1; ext_busy_r_n = 1;
        tick(); tick();
    endtask

    task automatic t_reset();
        rst_n = 0;
        ce_l = 1; ce_r = 1; addr_l = 3; addr_r = 3;
        wr_l = 1; wr_r = 1; wvalid_l = 1; wvalid_r = 1;
        tick(); tick();
        chk("R1 busy_l_n in reset", busy_l_n, 1'b1);
        chk("R1 busy_r_n in reset", busy_r_n, 1'b1);
        chk("R1 we_l in reset", we_l, 1'b0);
        chk("R1 we_r in reset", we_r, 1'b0);
        rst_n = 1;
        idle();
    endtask

    task automatic t_addr_order();
        idle();
        ce_l = 1; addr_l = 3; ce_r = 1; addr_r = 7; tick();
        chk("R3 no busy on distinct addresses", busy_r_n, 1'b1);
        addr_r = 3; tick();
        chk("R2 right moved onto left: busy_r_n", busy_r_n, 1'b0);
        chk("R2 right moved onto left: busy_l_n", busy_l_n, 1'b1);
        tick();
        chk("R2 busy_r_n held", busy_r_n, 1'b0);
        addr_r = 8; tick();
        chk("R3 busy_r_n released", busy_r_n, 1'b1);
        idle();
        ce_l = 1; addr_l = 3; ce_r = 1; addr_r = 7; tick();
        addr_l = 7; tick();
        chk("R2 left moved onto right: busy_l_n", busy_l_n, 1'b0);
        chk("R2 left moved onto right: busy_r_n", busy_r_n, 1'b1);
        addr_l = 2; tick();
        chk("R3 busy_l_n released", busy_l_n, 1'b1);
    endtask

    task automatic t_ce_order();
        idle();
        ce_l = 1; addr_l = 5; tick();
        ce_r = 1; addr_r = 5; tick();
        chk("R4 right enabled later: busy_r_n", busy_r_n, 1'b0);
        ce_l = 0; tick();
        chk("R5 left winner disabled: busy_r_n", busy_r_n, 1'b1);
        idle();
        ce_r = 1; addr_r = 5; tick();
        ce_l = 1; addr_l = 5; tick();
        chk("R4 left enabled later: busy_l_n", busy_l_n, 1'b0);
        chk("R9 busy_r_n stays high", busy_r_n, 1'b1);
        ce_r = 0; tick();
        chk("R5 right winner disabled: busy_l_n", busy_l_n, 1'b1);
    endtask

    task automatic t_simultaneous();
        idle();
        ce_l = 1; ce_r = 1; addr_l = 9; addr_r = 9; tick();
        chk("R6 enables together: busy_r_n", busy_r_n, 1'b0);
        chk("R6 enables together: busy_l_n", busy_l_n, 1'b1);
        chk("R9 not both busy", busy_l_n | busy_r_n, 1'b1);
        idle();
        ce_l = 1; ce_r = 1; addr_l = 1; addr_r = 2; tick();
        addr_l = 4; addr_r = 4; tick();
        chk("R6 addresses together: busy_r_n", busy_r_n, 1'b0);
        chk("R6 addresses together: busy_l_n", busy_l_n, 1'b1);
    endtask

    task automatic t_write_block();
        idle();
        ce_l = 1; addr_l = 6; wr_l = 1; wvalid_l = 1; tick();
        chk("R7 lone left write passes", we_l, 1'b1);
        ce_r = 1; addr_r = 6; wr_r = 1; wvalid_r = 1; tick();
        chk("R7 loser write blocked", we_r, 1'b0);
        chk("R7 winner write passes", we_l, 1'b1);
        addr_r = 0; tick();
        chk("R7 write passes after collision ends", we_r, 1'b1);
    endtask

    task automatic t_wvalid();
        idle();
        ce_l = 1; addr_l = 2; wr_l = 1; wvalid_l = 0; tick();
        chk("R11 no strobe without wvalid", we_l, 1'b0);
    endtask

    task automatic t_disabled();
        idle();
        ce_l = 1; addr_l = 2; ce_r = 0; addr_r = 2; tick(); tick();
        chk("R10 right disabled: busy_l_n", busy_l_n, 1'b1);
        chk("R10 right disabled: busy_r_n", busy_r_n, 1'b1);
    endtask

    task automatic t_slave();
        mode_master = 0;
        idle();
        ce_l = 1; ce_r = 1; addr_l = 11; addr_r = 11;
        wr_l = 1; wr_r = 1; wvalid_l = 1; wvalid_r = 1;
        ext_busy_l_n = 1; ext_busy_r_n = 0; tick();
        chk("R8 slave busy_l_n high", busy_l_n, 1'b1);
        chk("R8 slave busy_r_n high", busy_r_n, 1'b1);
        chk("R8 slave left write passes", we_l, 1'b1);
        chk("R8 slave right write blocked", we_r, 1'b0);
        ext_busy_l_n = 0; ext_busy_r_n = 1; tick();
        chk("R8 slave left write blocked", we_l, 1'b0);
        chk("R8 slave right write passes", we_r, 1'b1);
        mode_master = 1;
        idle();
        ce_l = 1; addr_l = 4; wr_l = 1; wvalid_l = 1; ext_busy_l_n = 0; tick();
        chk("R8 master ignores external busy", we_l, 1'b1);
        idle();
    endtask

    initial begin
        t_reset();
        t_addr_order();
        t_ce_order();
        t_simultaneous();
        t_write_block();
        t_wvalid();
        t_disabled();
        t_slave();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule